// File: doc/BRIEF.md
# Coarse-Update Shared Real-Time Counter

This block holds one 64-bit real-time value that every hart in a cluster reads through its own read port. Software treats the value as if it advanced at a fine tick rate. In hardware the stored value changes only on a slower update strobe. Each strobe adds a fixed increment, and that increment equals the number of apparent ticks in one update period. For example, a 1 GHz apparent tick updated at 100 MHz steps by 10 each time.

All read ports are fed from a single register, so every hart sees each update in the same clock cycle. Readers on different harts can therefore never disagree by more than one update step. Between strobes, any number of reads return the same value. Machine-level software can load a new 64-bit value through the write port. Counting then continues from that value at the next strobe, and the strobe phase does not shift.

Top module: `rtclk_shared_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every read port returns 0.
- R2: Between two update strobes, with no write, every read port holds its value unchanged.
- R3: Each update strobe with no write in the same cycle adds exactly TICK_STEP (default 10) to the stored value.
- R4: The update strobe fires every UPDATE_DIV clock cycles (default 10). The first update after reset lands on the UPDATE_DIV-th rising edge after release, so a new value is visible at least once per update period.
- R5: All NUM_PORTS read ports return an identical value in every cycle.
- R6: When no write occurs and the value does not wrap, the value seen on a port never decreases from one cycle to the next.
- R7: A write with `sw_wr_en` high loads `sw_wr_data` into the counter on that clock edge. A write takes priority over an update strobe in the same cycle, and that strobe's increment is dropped.
- R8: A write does not reset the strobe phase. The next increment from the written value lands on the next strobe of the original schedule.
- R9: The counter wraps modulo 2^64. For example, 2^64-5 plus a step of 10 gives 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the counter and the strobe divider |
| sw_wr_en | input | 1 | Software load request for this cycle |
| sw_wr_data | input | 64 | Value to load when `sw_wr_en` is high |
| hart_time | output | NUM_PORTS x 64 | One 64-bit read value per hart; all driven from the shared register |

## Verification
The embedded properties check these rules on every cycle:
- all ports agree;
- the value holds between strobes;
- each strobe adds exactly one step;
- a write loads its data;
- the value is monotonic except at wrap;
- the divider stays inside its range.

Only the bench scenarios can show the absolute timing of the first update after reset, and that a write leaves the strobe phase in place. They also show that a write dropping a coincident strobe is followed by a full period before the next increment, and the exact wrapped result near 2^64.

// File: rtl/rtclk_pkg.sv
package rtclk_pkg;
  localparam int RTC_W = 64;
  typedef logic [RTC_W-1:0] rtc_time_t;

  // Advance the stored time by one update step; wraps modulo 2^64.
  function automatic rtc_time_t rtc_advance(input rtc_time_t cur, input rtc_time_t step);
    return cur + step;
  endfunction

  // True when adding step would wrap past 2^64.
  function automatic logic rtc_will_wrap(input rtc_time_t cur, input rtc_time_t step);
    return cur > (~step);
  endfunction
endpackage

// File: rtl/rtclk_update_divider.sv
module rtclk_update_divider #(
  parameter int UPDATE_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic update_strobe
);
  localparam int CW = (UPDATE_DIV > 1) ? $clog2(UPDATE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(UPDATE_DIV - 1);

  generate
    if (UPDATE_DIV <= 1) begin : g_every_cycle
      assign update_strobe = 1'b1;
    end else begin : g_divided
      logic [CW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
      end

      assign update_strobe = (phase_q == LAST);

      // R4: divider never leaves its range
      p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
      // R4: a strobe is followed by a gap
      p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |=> !update_strobe);
    end
  endgenerate
endmodule

// File: rtl/rtclk_time_reg.sv
module rtclk_time_reg
  import rtclk_pkg::*;
#(
  parameter rtc_time_t TICK_STEP = 64'd10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      update_strobe,
  input  logic      load_en,
  input  rtc_time_t load_value,
  output rtc_time_t time_q
);
  logic      step_event;
  logic      wrap_event;
  rtc_time_t time_d;

  assign step_event = update_strobe && !load_en;
  assign wrap_event = step_event && rtc_will_wrap(time_q, TICK_STEP);

  always_comb begin
    time_d = time_q;
    if (load_en)         time_d = load_value;
    else if (step_event) time_d = rtc_advance(time_q, TICK_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> time_q == '0);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !update_strobe) |=> $stable(time_q));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (update_strobe && !load_en) |=> (time_q - $past(time_q)) == TICK_STEP);
  p_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !wrap_event) |=> time_q >= $past(time_q));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> time_q == $past(load_value));
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_event |=> time_q < $past(time_q));
endmodule

// File: rtl/rtclk_read_fanout.sv
module rtclk_read_fanout
  import rtclk_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  rtc_time_t                      shared_time,
  output logic [NUM_PORTS-1:0][RTC_W-1:0] port_time
);
  generate
    for (genvar h = 0; h < NUM_PORTS; h++) begin : g_port
      assign port_time[h] = shared_time;
    end
  endgenerate
endmodule

// File: rtl/rtclk_shared_counter.sv
module rtclk_shared_counter
  import rtclk_pkg::*;
#(
  parameter int        NUM_PORTS  = 4,
  parameter int        UPDATE_DIV = 10,
  parameter rtc_time_t TICK_STEP  = 64'd10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sw_wr_en,
  input  logic [63:0]                    sw_wr_data,
  output logic [NUM_PORTS-1:0][63:0]     hart_time
);
  logic      update_strobe;
  rtc_time_t shared_time;

  rtclk_update_divider #(.UPDATE_DIV(UPDATE_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .update_strobe(update_strobe)
  );

  rtclk_time_reg #(.TICK_STEP(TICK_STEP)) u_time (
    .clk(clk), .rst_n(rst_n), .update_strobe(update_strobe),
    .load_en(sw_wr_en), .load_value(sw_wr_data), .time_q(shared_time)
  );

  rtclk_read_fanout #(.NUM_PORTS(NUM_PORTS)) u_fanout (
    .shared_time(shared_time), .port_time(hart_time)
  );

  generate
    for (genvar h = 1; h < NUM_PORTS; h++) begin : g_eq
      p_ports_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hart_time[h] == hart_time[0]);
    end
  endgenerate
endmodule

// File: tb/rtclk_shared_counter_tb_top.sv
module rtclk_shared_counter_tb_top;
  localparam int          NP   = 4;
  localparam int          DIV  = 10;
  localparam logic [63:0] STEP = 64'd10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr_en = 1'b0;
  logic [63:0] sw_wr_data = '0;
  logic [NP-1:0][63:0] hart_time;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // Bench reference: phase counter and expected time, restated from R3/R4/R7/R8.
  int ph = 0;
  logic [63:0] exp_t = '0;

  always #10 clk = ~clk;

  rtclk_shared_counter #(.NUM_PORTS(NP), .UPDATE_DIV(DIV), .TICK_STEP(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .hart_time(hart_time)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; exp_t <= '0;
    end else begin
      ph <= (ph == DIV-1) ? 0 : ph + 1;
      if (sw_wr_en)        exp_t <= sw_wr_data;
      else if (ph == DIV-1) exp_t <= exp_t + STEP;
    end
    cyc <= cyc + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic chk_all(input string req);
    for (int h = 0; h < NP; h++) chk(req, hart_time[h], exp_t);
  endtask

  task automatic t_reset();
    chk_all("R1");
    @(negedge clk); rst_n = 1'b1;
    chk_all("R1");
    @(negedge clk);
    chk("R1", hart_time[0], 64'd0);
  endtask

  task automatic t_first_update();
    // one edge already since release; update on edge DIV
    repeat (DIV-2) @(negedge clk);
    chk("R4", hart_time[0], 64'd0);
    @(negedge clk);
    chk("R4", hart_time[0], STEP);
    chk_all("R5");
  endtask

  task automatic t_hold_and_step();
    logic [63:0] prev;
    prev = hart_time[0];
    for (int k = 0; k < 3*DIV; k++) begin
      @(negedge clk);
      if (hart_time[0] < prev) chk("R6", hart_time[0], prev);
      for (int h = 1; h < NP; h++) chk("R5", hart_time[h], hart_time[0]);
      prev = hart_time[0];
    end
    chk_all("R2");
    chk("R3", hart_time[0], STEP * 4);
  endtask

  task automatic t_write_phase();
    while (ph != 3) @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = 64'd1000;
    @(negedge clk); sw_wr_en = 1'b0;
    chk("R7", hart_time[2], 64'd1000);
    // phase now 4; next strobe edge occurs when phase 9 is consumed
    repeat (DIV-5) @(negedge clk);
    chk("R8", hart_time[1], 64'd1000);
    @(negedge clk);
    chk("R8", hart_time[1], 64'd1010);
    chk_all("R8");
  endtask

  task automatic t_collision();
    while (ph != DIV-1) @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = 64'h0000_1234_0000_0000;
    @(negedge clk); sw_wr_en = 1'b0;
    chk("R7", hart_time[0], 64'h0000_1234_0000_0000);
    repeat (DIV-1) @(negedge clk);
    chk("R2", hart_time[3], 64'h0000_1234_0000_0000);
    @(negedge clk);
    chk("R3", hart_time[3], 64'h0000_1234_0000_0000 + STEP);
  endtask

  task automatic t_wrap();
    while (ph != 2) @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = 64'hFFFF_FFFF_FFFF_FFFB;
    @(negedge clk); sw_wr_en = 1'b0;
    chk("R9", hart_time[0], 64'hFFFF_FFFF_FFFF_FFFB);
    while (ph != 0) @(negedge clk);
    chk("R9", hart_time[0], 64'd5);
    chk_all("R9");
  endtask

  initial begin
    t_reset();
    t_first_update();
    t_hold_and_step();
    t_write_phase();
    t_collision();
    t_wrap();
    repeat (2) @(negedge clk);
    chk_all("R5");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule